// File: doc/BRIEF.md
# UART Interrupt Combiner and Identification

This block gathers the interrupt conditions of a UART into one interrupt line for the host and a small identification register that names the most urgent pending cause. Line status, receive data available and receive timeout arrive as level inputs from the receive side. Two conditions are tracked inside the block:

- The transmit data request, whose trigger depends on the FIFO mode select.
- The modem status change, which is latched from the delta bits.

Each of the five sources has an enable bit. A source whose bit is cleared is left out of both the interrupt line and the identification code. With no enables set, software polls the line status instead. The receive and transmit enables are separate bits, so either direction can be polled on its own.

The host reaches two registers through a one-bit address: the enable register at address 0 and the identification register at address 1. Read data is registered. A read of the identification register has a side effect: if that read reports the transmit request, the request is retired. Writing a character to the transmit holding register or FIFO also retires it. A read of the modem status register, signalled by its own strobe, retires the modem interrupt.

Top module: `uart_irq_ctrl`

## Requirements
- R1: The enable register sits at address 0 and holds 5 bits. The bits are: bit 0 receive data available, bit 1 transmit request, bit 2 line status, bit 3 modem status, bit 4 receive timeout. A write to address 0 loads these bits from reg_wdata[4:0]. A read of address 0 returns them with bits 7:5 as zero. Writes to address 1 change nothing.
- R2: With fifo_mode low, the transmit request becomes pending one cycle after tx_level goes from nonzero to zero, which means the holding register has emptied.
- R3: With fifo_mode high, the transmit request becomes pending one cycle after tx_level goes from above 32 to 32 or below, on a 64-entry FIFO.
- R4: Once cleared, the transmit request does not return while its empty or half-empty condition simply persists. Only a new crossing into that condition sets it again.
- R5: A thr_wr strobe clears the transmit request. A read of address 1 also clears it, but only if that read returns the transmit request code. A read that returns another code leaves the request pending.
- R6: Any set bit of msr_delta makes the modem interrupt pending. It stays pending until an msr_rd strobe clears it.
- R7: A cleared enable bit removes its source from irq and from the identification code. A latched source stays pending while masked and appears again once it is re-enabled.
- R8: A read of address 1 returns the code of the highest-priority enabled pending source, in bits 3:0 with bits 7:4 as zero. From highest to lowest: line status 0x06, receive data 0x04, receive timeout 0x0C, transmit request 0x02, modem status 0x00. With nothing pending it returns 0x01, so bit 0 is low exactly when an interrupt is pending.
- R9: irq equals the OR of all enabled pending sources, delayed by one register stage.
- R10: reg_rdata updates on the clock edge that samples reg_rd and holds its value in all other cycles.
- R11: Reset is synchronous and active high. It clears the enables, both latched sources, irq and reg_rdata.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single holding register mode |
| tx_level | input | 7 | Characters still waiting to be sent (0 to 64) |
| thr_wr | input | 1 | Strobe for a write to the transmit holding register or FIFO |
| msr_rd | input | 1 | Strobe for a host read of the modem status register |
| msr_delta | input | 4 | Modem status change bits (clear-to-send, data-set-ready, ring, carrier detect) |
| line_stat | input | 1 | Line status error condition from the receiver |
| rx_avail | input | 1 | Receive data available condition |
| rx_timeout | input | 1 | Receive character timeout condition |
| reg_addr | input | 1 | Register select: 0 enable, 1 identification |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt request |

## Verification
A stuck or lost transmit request latch shows up two edges after the level change. It appears on irq and in the next identification read, as a missing 0x02 or a 0x02 that reappears without a new crossing. A wrong priority order or a mask that discards state shows in the code returned by the first read after two sources overlap, or after an enable is turned back on. A modem latch that clears early, or fails to clear, shows on irq two edges after the delta or the msr_rd strobe.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC   = 5;
  // source indices, equal to enable register bit positions
  localparam int S_RDA  = 0;
  localparam int S_TX   = 1;
  localparam int S_LS   = 2;
  localparam int S_MS   = 3;
  localparam int S_TO   = 4;

  localparam logic [3:0] ID_NONE = 4'b0001;
  localparam logic [3:0] ID_LS   = 4'b0110;
  localparam logic [3:0] ID_RDA  = 4'b0100;
  localparam logic [3:0] ID_TO   = 4'b1100;
  localparam logic [3:0] ID_TX   = 4'b0010;
  localparam logic [3:0] ID_MS   = 4'b0000;
endpackage

// File: rtl/uart_irq_txreq.sv
module uart_irq_txreq #(
  parameter int DEPTH = 64,
  parameter int LW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic [LW-1:0] level,
  input  logic          clr,
  output logic          cond,
  output logic          pend
);
  localparam logic [LW-1:0] HALF = LW'(DEPTH / 2);

  logic cond_q;

  // empty holding register, or FIFO at half or below
  assign cond = fifo_mode ? (level <= HALF) : (level == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b0;
      pend   <= 1'b0;
    end else begin
      cond_q <= cond;
      if (cond && !cond_q) pend <= 1'b1;   // a new crossing wins over a clear
      else if (clr)        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_msr.sv
module uart_irq_msr #(
  parameter int MS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [MS_W-1:0] delta,
  input  logic            rd,
  output logic            pend
);
  always_ff @(posedge clk) begin
    if (rst)     pend <= 1'b0;
    else if (rd) pend <= 1'b0;
    else         pend <= pend | (|delta);
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_en,
  output logic [3:0]      code
);
  always_comb begin
    if      (pend_en[S_LS])  code = ID_LS;
    else if (pend_en[S_RDA]) code = ID_RDA;
    else if (pend_en[S_TO])  code = ID_TO;
    else if (pend_en[S_TX])  code = ID_TX;
    else if (pend_en[S_MS])  code = ID_MS;
    else                     code = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int TX_DEPTH = 64,
  parameter int MS_W     = 4,
  parameter int DW       = 8,
  parameter int LVL_W    = $clog2(TX_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fifo_mode,
  input  logic [LVL_W-1:0] tx_level,
  input  logic             thr_wr,
  input  logic             msr_rd,
  input  logic [MS_W-1:0]  msr_delta,
  input  logic             line_stat,
  input  logic             rx_avail,
  input  logic             rx_timeout,
  input  logic             reg_addr,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata,
  output logic             irq
);
  logic [NSRC-1:0] en_q;
  logic [NSRC-1:0] src_pend;
  logic [NSRC-1:0] pend_en;
  logic [3:0]      id_code;
  logic            tx_cond;
  logic            tx_pend;
  logic            ms_pend;
  logic            id_rd;
  logic            tx_clr;

  assign id_rd  = reg_rd && reg_addr;
  assign tx_clr = thr_wr || (id_rd && (id_code == ID_TX));

  uart_irq_txreq #(.DEPTH(TX_DEPTH), .LW(LVL_W)) u_tx (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .level(tx_level),
    .clr(tx_clr), .cond(tx_cond), .pend(tx_pend)
  );

  uart_irq_msr #(.MS_W(MS_W)) u_ms (
    .clk(clk), .rst(rst), .delta(msr_delta), .rd(msr_rd), .pend(ms_pend)
  );

  always_comb begin
    src_pend        = '0;
    src_pend[S_RDA] = rx_avail;
    src_pend[S_TX]  = tx_pend;
    src_pend[S_LS]  = line_stat;
    src_pend[S_MS]  = ms_pend;
    src_pend[S_TO]  = rx_timeout;
  end

  assign pend_en = src_pend & en_q;

  uart_irq_prio u_prio (.pend_en(pend_en), .code(id_code));

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= '0;
      reg_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= |pend_en;
      if (reg_wr && !reg_addr) en_q <= reg_wdata[NSRC-1:0];
      if (reg_rd) reg_rdata <= reg_addr ? DW'(id_code) : DW'(en_q);
    end
  end
endmodule

// File: rtl/uart_irq_ctrl_chk.sv
module uart_irq_ctrl_chk #(
  parameter int DW   = 8,
  parameter int NSRC = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            thr_wr,
  input logic            msr_rd,
  input logic            reg_rd,
  input logic            reg_addr,
  input logic [DW-1:0]   reg_rdata,
  input logic            irq,
  input logic [NSRC-1:0] pend_en,
  input logic            tx_cond,
  input logic            tx_pend,
  input logic            ms_pend
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  // R9: irq follows enabled pending sources one cycle later
  p_irq_lat_r9: assert property (@(posedge clk) disable iff (rst)
    armed |-> (irq == $past(|pend_en)));

  // R4: the transmit request only rises while its condition holds
  p_tx_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (armed && $rose(tx_pend)) |-> $past(tx_cond));

  // R5: a holding register write retires the request
  p_tx_clr_r5: assert property (@(posedge clk) disable iff (rst)
    (thr_wr && !tx_cond) |=> !tx_pend);

  // R6: modem interrupt held until read, cleared by read
  p_ms_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (ms_pend && !msr_rd) |=> ms_pend);
  p_ms_clr_r6: assert property (@(posedge clk) disable iff (rst)
    msr_rd |=> !ms_pend);

  // R8: nothing pending reads back as the idle code
  p_id_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr && (pend_en == '0)) |=> (reg_rdata == DW'(1)));

  // R10: read data holds without a read strobe
  p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> $stable(reg_rdata));
endmodule

bind uart_irq_ctrl uart_irq_ctrl_chk #(.DW(DW), .NSRC(uart_irq_pkg::NSRC)) u_chk (
  .clk(clk), .rst(rst), .thr_wr(thr_wr), .msr_rd(msr_rd), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .irq(irq), .pend_en(pend_en),
  .tx_cond(tx_cond), .tx_pend(tx_pend), .ms_pend(ms_pend)
);

// File: tb/tb_uart_irq_ctrl.sv
`timescale 1ns/1ps
module tb_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic       fifo_mode;
  logic [6:0] tx_level;
  logic       thr_wr, msr_rd;
  logic [3:0] msr_delta;
  logic       line_stat, rx_avail, rx_timeout;
  logic       reg_addr, reg_wr, reg_rd;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .tx_level(tx_level),
    .thr_wr(thr_wr), .msr_rd(msr_rd), .msr_delta(msr_delta),
    .line_stat(line_stat), .rx_avail(rx_avail), .rx_timeout(rx_timeout),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  // {mode, en[4:0], ls, rda, to, delta[3:0], level[6:0], exp_irq, exp_id[7:0]}
  localparam logic [28:0] TBL [16] = '{
    {1'b0, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd1,  1'b0, 8'h01}, // R8 idle
    {1'b0, 5'h1F, 1'b0, 1'b1, 1'b0, 4'h0, 7'd1,  1'b1, 8'h04}, // R8 rx data
    {1'b0, 5'h1F, 1'b1, 1'b1, 1'b0, 4'h0, 7'd1,  1'b1, 8'h06}, // R8 line over rx
    {1'b0, 5'h1F, 1'b0, 1'b0, 1'b1, 4'h0, 7'd1,  1'b1, 8'h0C}, // R8 timeout
    {1'b0, 5'h1F, 1'b0, 1'b1, 1'b1, 4'h0, 7'd1,  1'b1, 8'h04}, // R8 rx over timeout
    {1'b0, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd0,  1'b1, 8'h02}, // R2 emptied
    {1'b0, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd0,  1'b0, 8'h01}, // R4 stays clear
    {1'b0, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd5,  1'b0, 8'h01}, // R2 refilled
    {1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd33, 1'b0, 8'h01}, // R3 above half
    {1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd32, 1'b1, 8'h02}, // R3 at half
    {1'b1, 5'h1F, 1'b0, 1'b1, 1'b0, 4'h0, 7'd32, 1'b1, 8'h04}, // R4 no re-rise
    {1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd40, 1'b0, 8'h01}, // R3 idle
    {1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h4, 7'd40, 1'b1, 8'h00}, // R6 delta
    {1'b1, 5'h17, 1'b0, 1'b0, 1'b0, 4'h0, 7'd40, 1'b0, 8'h01}, // R7 modem masked
    {1'b1, 5'h1F, 1'b1, 1'b0, 1'b0, 4'h0, 7'd40, 1'b1, 8'h06}, // R8 line over modem
    {1'b1, 5'h1F, 1'b0, 1'b0, 1'b0, 4'h0, 7'd40, 1'b1, 8'h00}  // R7 modem kept
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic write_en(input logic [7:0] v);
    reg_addr = 1'b0; reg_wdata = v; reg_wr = 1'b1;
    step(1);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic a);
    reg_addr = a; reg_rd = 1'b1;
    step(1);
    reg_rd = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst = 1'b1; fifo_mode = 1'b0; tx_level = 7'd1; thr_wr = 1'b0; msr_rd = 1'b0;
    msr_delta = '0; line_stat = 1'b0; rx_avail = 1'b0; rx_timeout = 1'b0;
    reg_addr = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_wdata = '0;
    step(3);
    rst = 1'b0;

    // R11 reset state
    check("R11 irq", {7'd0, irq}, 8'h00);
    check("R11 rdata", reg_rdata, 8'h00);
    read_reg(1'b0);
    check("R11 enables", reg_rdata, 8'h00);

    // R1 enable register width and readback
    write_en(8'hFF);
    read_reg(1'b0);
    check("R1 upper bits zero", reg_rdata, 8'h1F);
    write_en(8'h15);
    reg_addr = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1; step(1); reg_wr = 1'b0;
    read_reg(1'b0);
    check("R1 readback, address 1 write ignored", reg_rdata, 8'h15);

    // vector table
    for (int i = 0; i < 16; i++) begin
      logic [28:0] v;
      v = TBL[i];
      write_en({3'b000, v[27:23]});
      fifo_mode = v[28]; line_stat = v[22]; rx_avail = v[21]; rx_timeout = v[20];
      msr_delta = v[19:16]; tx_level = v[15:9];
      step(2);
      check($sformatf("R9 table irq step %0d", i), {7'd0, irq}, {7'd0, v[8]});
      read_reg(1'b1);
      check($sformatf("R8 table id step %0d", i), reg_rdata, v[7:0]);
    end

    // R6 modem read clears
    msr_rd = 1'b1; step(1); msr_rd = 1'b0; step(1);
    check("R6 irq after msr read", {7'd0, irq}, 8'h00);
    read_reg(1'b1);
    check("R6 id after msr read", reg_rdata, 8'h01);

    // R5 holding register write clears
    fifo_mode = 1'b0; tx_level = 7'd5; step(2);
    tx_level = 7'd0; step(2);
    check("R2 irq on empty", {7'd0, irq}, 8'h01);
    thr_wr = 1'b1; step(1); thr_wr = 1'b0; step(1);
    check("R5 irq after thr write", {7'd0, irq}, 8'h00);
    read_reg(1'b1);
    check("R4 id stays idle while empty", reg_rdata, 8'h01);

    // R5 read reporting another code keeps request
    tx_level = 7'd5; step(1);
    line_stat = 1'b1; step(1);
    tx_level = 7'd0; step(2);
    read_reg(1'b1);
    check("R8 line over tx", reg_rdata, 8'h06);
    line_stat = 1'b0; step(2);
    read_reg(1'b1);
    check("R5 tx kept after other read", reg_rdata, 8'h02);
    read_reg(1'b1);
    check("R5 tx cleared by own read", reg_rdata, 8'h01);

    // R10 read data holds
    line_stat = 1'b1; step(2);
    check("R10 rdata holds", reg_rdata, 8'h01);
    line_stat = 1'b0;

    // R7 masked tx request kept while transmit polled
    tx_level = 7'd5; step(1);
    write_en(8'h11);
    tx_level = 7'd0; step(2);
    check("R7 masked irq", {7'd0, irq}, 8'h00);
    read_reg(1'b1);
    check("R7 masked id", reg_rdata, 8'h01);
    write_en(8'h13); step(1);
    check("R7 unmasked irq", {7'd0, irq}, 8'h01);
    read_reg(1'b1);
    check("R7 unmasked id", reg_rdata, 8'h02);

    finish_run();
  end
endmodule